// File: doc/BRIEF.md
# Write-Once Cache Line Coherence Controller

This block keeps the lines of one private cache coherent with the other caches on a shared bus. It uses a write-once policy. The first processor write to a line that may be shared goes through to memory, and that same bus transaction invalidates every other copy. Later writes to the line stay in the cache and are copied back only on eviction. The block needs no "line is shared" feedback from the bus, so any plain address/data bus with snooping will carry it.

Each line is in one of four states: invalid, valid (clean and possibly shared), reserved (clean and held only here) or dirty (modified and held only here). A small direct-mapped table holds the tag, state and one data word of each line. Processor requests are served from the table when possible. Otherwise the block issues one bus transaction: a read, a read-for-ownership, a write-through that invalidates, or a copy-back. It snoops the transactions of the other caches. When another cache reads a dirty line, this block supplies the data, and memory captures the same data. A one-word line is filled or written as a whole.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: A processor read whose tag matches a non-invalid line is answered one cycle after acceptance with `rsp_valid` and the line data, and no bus transaction is made.
- R2: A processor read that misses raises `bus_req` with `bus_cmd` = 0 (read) at the request address. In the cycle after `bus_gnt`, `rsp_valid` returns the `bus_rdata` word sampled with the grant, and the line is left valid.
- R3: A processor write that hits a reserved or dirty line updates the line locally with no bus transaction, answers one cycle later, and leaves the line dirty.
- R4: A processor write that hits a valid line issues `bus_cmd` = 2 (write-through with invalidate) carrying the write data. After the grant the line is reserved, so the next write to it is local.
- R5: A processor write that misses issues `bus_cmd` = 1 (read for ownership). After the grant the line holds the write data and is dirty.
- R6: A snooped read (`snp_cmd` = 0) that hits a dirty line raises `snp_supply` in the same cycle, with the line data on `snp_data`. The line is valid afterwards.
- R7: A snooped read that hits a reserved or valid line does not raise `snp_supply`, and the line becomes or stays valid.
- R8: A snooped invalidate (`snp_cmd` = 2) or read for ownership (`snp_cmd` = 1) that hits sends the line to invalid. A read for ownership that hits a dirty line raises `snp_supply` with the data first. `snp_cmd` = 3 (copy-back) has no effect.
- R9: `busy` is high while the block's own bus transaction is pending and in any cycle with `snp_valid`. A request is taken only when `busy` is low. A request held during a snoop is taken after the snoop, and the snoop's effect is seen first.
- R10: A miss whose indexed line is dirty with another tag first issues `bus_cmd` = 3 (copy-back) with the old address and data, then the fill. A reserved or valid victim is replaced silently.
- R11: The bus command of a pending transaction follows the current line state. A line invalidated by a snoop while a write-through waits for its grant makes the command become a read for ownership.
- R12: After reset every line is invalid, and `busy`, `bus_req`, `rsp_valid` and `snp_supply` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present, held until taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Processor word address (low IDX_W bits index the table) |
| req_wdata | input | DATA_W | Processor write data |
| busy | output | 1 | Request cannot be taken this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, or written data for writes |
| bus_req | output | 1 | Own bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 read for ownership, 2 write-through invalidate, 3 copy-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Data for commands 2 and 3 |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies data; memory takes it too |
| snp_data | output | DATA_W | Supplied data |

## Verification
A snoop can fall in the same cycle as a processor request, or in a cycle where the block's own transaction is still waiting for its grant. Both cases are driven on purpose. A write to a valid line is presented together with a snooped invalidate of that line, and a pending write-through is invalidated before its grant. The expected result is that the snoop wins: the request is deferred and the command becomes a read for ownership. A long random phase mixes held requests, delayed grants and snoops over a few conflicting addresses. A behavioural model in the bench judges the phase cycle by cycle.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_V = 2'd1,
    LS_R = 2'd2,
    LS_D = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_RWITM = 2'd1,
    BC_WTINV = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/wo_line_table.sv
module wo_line_table #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sn_we,
  input  logic [IDX_W-1:0]                sn_idx,
  input  logic [1:0]                      sn_st,
  input  logic                            pr_we,
  input  logic [IDX_W-1:0]                pr_idx,
  input  logic [TAG_W-1:0]                pr_tag,
  input  logic [1:0]                      pr_st,
  input  logic [DATA_W-1:0]               pr_data,
  output logic [(1<<IDX_W)-1:0][1:0]      line_st,
  output logic [(1<<IDX_W)-1:0][TAG_W-1:0]  line_tag,
  output logic [(1<<IDX_W)-1:0][DATA_W-1:0] line_data
);
  localparam int LINES = 1 << IDX_W;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0] st_d;
    logic       pr_hit_line;

    assign pr_hit_line = pr_we && (pr_idx == IDX_W'(g));

    always_comb begin
      st_d = line_st[g];
      if (sn_we && (sn_idx == IDX_W'(g))) st_d = sn_st;
      if (pr_hit_line)                    st_d = pr_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_st[g] <= wo_pkg::LS_I;
      else        line_st[g] <= st_d;
    end

    always_ff @(posedge clk) begin
      if (pr_hit_line) begin
        line_tag[g]  <= pr_tag;
        line_data[g] <= pr_data;
      end
    end
  end
endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [1:0]        sel_st,
  input  logic [TAG_W-1:0]  sel_tag,
  input  logic [DATA_W-1:0] sel_data,
  output logic              sn_we,
  output logic [1:0]        sn_st,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  import wo_pkg::*;

  logic hit;
  logic wants_data;

  assign hit        = (sel_st != LS_I) && (sel_tag == snp_tag);
  assign wants_data = (snp_cmd == BC_READ) || (snp_cmd == BC_RWITM);
  assign snp_supply = snp_valid && hit && (sel_st == LS_D) && wants_data;
  assign snp_data   = sel_data;
  assign sn_we      = snp_valid && hit && (snp_cmd != BC_WBACK);
  assign sn_st      = (snp_cmd == BC_READ) ? LS_V : LS_I;
endmodule

// File: rtl/wo_req_ctrl.sv
module wo_req_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        rq_st,
  input  logic [ADDR_W-IDX_W-1:0] rq_tag,
  input  logic [DATA_W-1:0] rq_data,
  input  logic [1:0]        op_st,
  input  logic [ADDR_W-IDX_W-1:0] op_ltag,
  input  logic [DATA_W-1:0] op_ldata,
  output logic [IDX_W-1:0]  op_idx,
  output logic              busy,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              pr_we,
  output logic [IDX_W-1:0]  pr_idx,
  output logic [ADDR_W-IDX_W-1:0] pr_tag,
  output logic [1:0]        pr_st,
  output logic [DATA_W-1:0] pr_data
);
  import wo_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic {PH_IDLE, PH_BUS} phase_e;

  phase_e            ph_q, ph_d;
  logic              op_wr_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic              op_en;
  logic              rsp_v_d;
  logic [DATA_W-1:0] rsp_d_d;
  logic [TAG_W-1:0]  req_tag, op_tag;
  logic              rq_hit, op_hit, victim_dirty, accept;

  assign req_tag      = req_addr[ADDR_W-1:IDX_W];
  assign op_tag       = op_addr_q[ADDR_W-1:IDX_W];
  assign op_idx       = op_addr_q[IDX_W-1:0];
  assign rq_hit       = (rq_st != LS_I) && (rq_tag == req_tag);
  assign op_hit       = (op_st != LS_I) && (op_ltag == op_tag);
  assign victim_dirty = (op_st == LS_D) && (op_ltag != op_tag);
  assign busy         = (ph_q == PH_BUS) || snp_valid;
  assign bus_req      = (ph_q == PH_BUS);
  assign accept       = (ph_q == PH_IDLE) && req_valid && !snp_valid;

  always_comb begin
    bus_cmd   = BC_READ;
    bus_addr  = op_addr_q;
    bus_wdata = op_data_q;
    if (victim_dirty) begin
      bus_cmd   = BC_WBACK;
      bus_addr  = {op_ltag, op_idx};
      bus_wdata = op_ldata;
    end else if (op_wr_q && op_hit) begin
      bus_cmd   = BC_WTINV;
    end else if (op_wr_q) begin
      bus_cmd   = BC_RWITM;
    end
  end

  always_comb begin
    ph_d    = ph_q;
    op_en   = 1'b0;
    rsp_v_d = 1'b0;
    rsp_d_d = rsp_rdata;
    pr_we   = 1'b0;
    pr_idx  = req_addr[IDX_W-1:0];
    pr_tag  = req_tag;
    pr_st   = LS_D;
    pr_data = req_wdata;
    if (accept) begin
      if (!req_write && rq_hit) begin
        rsp_v_d = 1'b1;
        rsp_d_d = rq_data;
      end else if (req_write && rq_hit && (rq_st == LS_R || rq_st == LS_D)) begin
        pr_we   = 1'b1;
        rsp_v_d = 1'b1;
        rsp_d_d = req_wdata;
      end else begin
        ph_d  = PH_BUS;
        op_en = 1'b1;
      end
    end else if (ph_q == PH_BUS && bus_gnt) begin
      pr_we   = 1'b1;
      pr_idx  = op_idx;
      pr_tag  = op_tag;
      pr_data = op_data_q;
      ph_d    = PH_IDLE;
      rsp_v_d = 1'b1;
      rsp_d_d = op_data_q;
      unique case (bus_cmd)
        BC_WBACK: begin
          pr_tag  = op_ltag;
          pr_data = op_ldata;
          pr_st   = LS_I;
          ph_d    = PH_BUS;
          rsp_v_d = 1'b0;
          rsp_d_d = rsp_rdata;
        end
        BC_WTINV: pr_st = LS_R;
        BC_RWITM: pr_st = LS_D;
        default: begin
          pr_st   = LS_V;
          pr_data = bus_rdata;
          rsp_d_d = bus_rdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      rsp_valid <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (op_en) begin
      op_wr_q   <= req_write;
      op_addr_q <= req_addr;
      op_data_q <= req_wdata;
    end
    if (rsp_v_d) rsp_rdata <= rsp_d_d;
  end

  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd != BC_WBACK |=> rsp_valid && !bus_req); // R2
  AST_WBACK_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == BC_WBACK |=> bus_req && !rsp_valid); // R10
  AST_SNOOP_DEFERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && ph_q == PH_IDLE |=> !rsp_valid && !bus_req); // R9
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  import wo_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [LINES-1:0][1:0]        tbl_st;
  logic [LINES-1:0][TAG_W-1:0]  tbl_tag;
  logic [LINES-1:0][DATA_W-1:0] tbl_data;

  logic              sn_we;
  logic [1:0]        sn_st;
  logic              pr_we;
  logic [IDX_W-1:0]  pr_idx, op_idx, rq_idx, sn_idx;
  logic [TAG_W-1:0]  pr_tag;
  logic [1:0]        pr_st;
  logic [DATA_W-1:0] pr_data;

  assign rq_idx = req_addr[IDX_W-1:0];
  assign sn_idx = snp_addr[IDX_W-1:0];

  wo_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_sync_n),
    .sn_we(sn_we), .sn_idx(sn_idx), .sn_st(sn_st),
    .pr_we(pr_we), .pr_idx(pr_idx), .pr_tag(pr_tag), .pr_st(pr_st), .pr_data(pr_data),
    .line_st(tbl_st), .line_tag(tbl_tag), .line_data(tbl_data)
  );

  wo_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .sel_st(tbl_st[sn_idx]), .sel_tag(tbl_tag[sn_idx]), .sel_data(tbl_data[sn_idx]),
    .sn_we(sn_we), .sn_st(sn_st), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  wo_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .rq_st(tbl_st[rq_idx]), .rq_tag(tbl_tag[rq_idx]), .rq_data(tbl_data[rq_idx]),
    .op_st(tbl_st[op_idx]), .op_ltag(tbl_tag[op_idx]), .op_ldata(tbl_data[op_idx]),
    .op_idx(op_idx), .busy(busy),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pr_we(pr_we), .pr_idx(pr_idx), .pr_tag(pr_tag), .pr_st(pr_st), .pr_data(pr_data)
  );

  AST_SNOOP_KILLS_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sn_we && sn_st == LS_I && !pr_we |=> tbl_st[$past(sn_idx)] == LS_I); // R8
  AST_SUPPLY_LEAVES_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snp_supply && snp_cmd == BC_READ && !pr_we |=> tbl_st[$past(sn_idx)] == LS_V); // R6
  AST_WTINV_RESERVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_req && bus_gnt && bus_cmd == BC_WTINV |=> tbl_st[$past(op_idx)] == LS_R); // R4
  AST_RWITM_DIRTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_req && bus_gnt && bus_cmd == BC_RWITM |=> tbl_st[$past(op_idx)] == LS_D); // R5
endmodule

// File: tb/wo_coherence_ctrl_bench.sv
module wo_coherence_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, rsp_valid, bus_req, snp_supply;
  logic [15:0] rsp_rdata, bus_wdata, snp_data;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wo_coherence_ctrl u_wo_coherence_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference model: state 0=I 1=V 2=R 3=D per line
  int ms[4], mt[4], md[4];
  bit m_pend, m_pw, m_rspv;
  int m_pa, m_pd, m_rspd;

  task automatic chk(input string lbl, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
    end
  endtask

  function automatic int exp_cmd();
    int li = m_pa % 4, pt = m_pa / 4;
    if (ms[li] == 3 && mt[li] != pt) return 3;
    if (m_pw && ms[li] != 0 && mt[li] == pt) return 2;
    if (m_pw) return 1;
    return 0;
  endfunction

  task automatic step(input string lbl, input bit rv, input bit rw, input int ra, input int rd,
                      input bit g, input bit sv, input int sc, input int sa, output bit acc);
    int cmd, li, si, st, rdv;
    bit shit, sup;
    req_valid = rv; req_write = rw; req_addr = 8'(ra); req_wdata = 16'(rd);
    snp_valid = sv; snp_cmd = 2'(sc); snp_addr = 8'(sa);
    bus_gnt = g && !sv;
    rdv = int'(16'($urandom));
    bus_rdata = 16'(rdv);
    #1;
    si = sa % 4; st = sa / 4;
    shit = (ms[si] != 0) && (mt[si] == st);
    sup = sv && shit && ms[si] == 3 && (sc == 0 || sc == 1);
    chk(lbl, "busy", int'(busy), int'(m_pend || sv));
    chk(lbl, "bus_req", int'(bus_req), int'(m_pend));
    cmd = exp_cmd();
    li = m_pa % 4;
    if (m_pend && bus_req) begin
      chk(lbl, "bus_cmd", int'(bus_cmd), cmd);
      chk(lbl, "bus_addr", int'(bus_addr), (cmd == 3) ? (mt[li] * 4 + li) : m_pa);
      if (cmd == 3) chk(lbl, "bus_wdata", int'(bus_wdata), md[li]);
      if (cmd == 2) chk(lbl, "bus_wdata", int'(bus_wdata), m_pd);
    end
    chk(lbl, "rsp_valid", int'(rsp_valid), int'(m_rspv));
    if (m_rspv && rsp_valid) chk(lbl, "rsp_rdata", int'(rsp_rdata), m_rspd);
    chk(lbl, "snp_supply", int'(snp_supply), int'(sup));
    if (sup && snp_supply) chk(lbl, "snp_data", int'(snp_data), md[si]);
    @(posedge clk);
    acc = 1'b0;
    m_rspv = 1'b0;
    if (sv && shit && sc != 3) ms[si] = (sc == 0) ? 1 : 0;
    if (!m_pend && rv && !sv) begin
      int ri = ra % 4, rt = ra / 4;
      bit rh = (ms[ri] != 0) && (mt[ri] == rt);
      acc = 1'b1;
      if (!rw && rh) begin m_rspv = 1; m_rspd = md[ri]; end
      else if (rw && rh && ms[ri] >= 2) begin ms[ri] = 3; md[ri] = rd; m_rspv = 1; m_rspd = rd; end
      else begin m_pend = 1; m_pw = rw; m_pa = ra; m_pd = rd; end
    end else if (m_pend && g && !sv) begin
      int pt = m_pa / 4;
      case (cmd)
        3: ms[li] = 0;
        2: begin ms[li] = 2; mt[li] = pt; md[li] = m_pd; m_rspv = 1; m_rspd = m_pd; m_pend = 0; end
        1: begin ms[li] = 3; mt[li] = pt; md[li] = m_pd; m_rspv = 1; m_rspd = m_pd; m_pend = 0; end
        default: begin ms[li] = 1; mt[li] = pt; md[li] = rdv; m_rspv = 1; m_rspd = rdv; m_pend = 0; end
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle(input string lbl);
    bit a;
    step(lbl, 0, 0, 0, 0, 0, 0, 0, 0, a);
  endtask

  // hold a request until taken and finished; grant after gdly waiting cycles
  task automatic do_req(input string lbl, input bit w, input int a, input int d, input int gdly);
    bit acc = 0;
    int waitc = 0;
    while (!acc) step(lbl, 1, w, a, d, 0, 0, 0, 0, acc);
    while (m_pend) begin
      step(lbl, 0, 0, 0, 0, waitc >= gdly, 0, 0, 0, acc);
      waitc++;
    end
    idle(lbl);
  endtask

  task automatic snoop(input string lbl, input int c, input int a);
    bit acc;
    step(lbl, 0, 0, 0, 0, 0, 1, c, a, acc);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit acc;
    bit held = 0, hw = 0;
    int ha = 0, hd = 0;
    for (int i = 0; i < 4; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
    m_pend = 0; m_pw = 0; m_rspv = 0; m_pa = 0; m_pd = 0; m_rspd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "bus_req", int'(bus_req), 0);
    chk("R12", "rsp_valid", int'(rsp_valid), 0);
    snoop("R12", 0, 8'h10);
    do_req("R2", 0, 8'h10, 0, 2);            // read miss, grant delayed
    do_req("R1", 0, 8'h10, 0, 0);            // read hit
    do_req("R4", 1, 8'h10, 16'h1111, 1);     // first write: write-through
    do_req("R3", 1, 8'h10, 16'h2222, 0);     // reserved: local
    do_req("R3", 1, 8'h10, 16'h3333, 0);     // dirty: local
    snoop("R6", 0, 8'h10);                   // supply from dirty
    idle("R6");
    do_req("R6", 1, 8'h10, 16'h4444, 0);     // valid again: write-through
    snoop("R7", 0, 8'h10);                   // reserved: no supply
    do_req("R7", 1, 8'h10, 16'h4545, 0);     // now valid: write-through
    snoop("R7", 0, 8'h10);
    do_req("R5", 1, 8'h24, 16'h5555, 1);     // write miss, silent replace (R10)
    snoop("R8", 3, 8'h24);                   // copy-back snoop ignored
    snoop("R8", 1, 8'h24);                   // rfo on dirty: supply then I
    do_req("R8", 0, 8'h24, 0, 0);            // must miss
    snoop("R8", 2, 8'h24);
    do_req("R8", 0, 8'h24, 0, 0);
    do_req("R4", 1, 8'h24, 16'h6666, 0);
    do_req("R3", 1, 8'h24, 16'h7777, 0);
    do_req("R10", 0, 8'h14, 0, 1);           // dirty victim copied back
    // R9: request in the same cycle as an invalidate of its line
    step("R9", 1, 1, 8'h14, 16'h8888, 0, 1, 2, 8'h14, acc);
    chk("R9", "deferred", int'(acc), 0);
    do_req("R9", 1, 8'h14, 16'h8888, 0);
    // R11: pending write-through invalidated before grant
    do_req("R11", 0, 8'h31, 0, 0);
    step("R11", 1, 1, 8'h31, 16'h9999, 0, 0, 0, 0, acc);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, acc);
    chk("R11", "pre_cmd", int'(bus_cmd), 2);
    snoop("R11", 2, 8'h31);
    chk("R11", "post_cmd", int'(bus_cmd), 1);
    while (m_pend) step("R11", 0, 0, 0, 0, 1, 0, 0, 0, acc);
    idle("R11");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit sv = ($urandom % 5) == 0;
      bit g = ($urandom % 3) == 0;
      int sa = int'($urandom % 3) * 4 + int'($urandom % 2);
      if (!held && ($urandom % 2) == 0) begin
        held = 1; hw = 1'($urandom);
        ha = int'($urandom % 3) * 4 + int'($urandom % 2);
        hd = int'(16'($urandom));
      end
      step("R11", held, hw, ha, hd, g, sv, int'($urandom % 4), sa, acc);
      if (acc) held = 0;
    end
    repeat (4) idle("R11");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule